// File: doc/BRIEF.md
# DDR Write Data Capture

This block is the receive side of the write data path in a double-data-rate memory device. The data bus is sampled on the rising and on the falling edge of a write strobe. Each rising/falling pair is joined into one core word twice as wide as the bus. Each core word goes to the array as one masked write, with one byte enable per byte lane of each beat.

A controller issues a write-start pulse in the core clock domain, together with a starting column and a burst length code. One core clock later the strobe begins toggling, centred in the data eye. It toggles once per beat pair. Captured pairs pass into the core clock domain through a two-entry ping-pong buffer at a fixed latency. The block then emits one core write per clock cycle with an incrementing word address until the burst is complete.

Top module: `ddr_wr_capture`

## Requirements
- R1: While reset is asserted and after it is released, with no accepted start, `core_we` is 0.
- R2: Each core word is `{falling-edge beat, rising-edge beat}`. The beat sampled on the rising strobe edge occupies bits DQ_W-1:0 and the falling-edge beat occupies bits 2*DQ_W-1:DQ_W.
- R3: Each beat has one mask bit per byte, where mask bit j covers bus bits 8j+7:8j. `core_be` bit b is the inverse of the mask bit sampled with the same byte. Bits NB-1:0 come from the rising-edge beat and bits 2*NB-1:NB come from the falling-edge beat, so a mask of 1 clears the enable.
- R4: The first core write uses word address `wr_col[COL_W-1:1]`, and column bit 0 is ignored. Each later write in the burst has an address one higher than the previous write, wrapping modulo 2^(COL_W-1).
- R5: The burst length code gives 1, 2 or 4 core writes: `wr_blen` 1 means 2 beats, 2 means 4 beats and 3 means 8 beats. A start with code 0 is ignored and produces no write.
- R6: A start sampled at clock edge T produces its first write with `core_we` high from edge T+3. The remaining writes follow on consecutive cycles.
- R7: A start pulse sampled while a burst is in progress is ignored. It adds no writes and does not change the addresses of the running burst.
- R8: `core_we` returns to 0 in the cycle after the last write of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_start | input | 1 | Write command pulse, core clock domain |
| wr_col | input | COL_W | Starting column in beats |
| wr_blen | input | 2 | Burst length code (1: 2 beats, 2: 4 beats, 3: 8 beats) |
| dqs | input | 1 | Write data strobe, both edges sample |
| dq | input | DQ_W | Write data bus |
| dm | input | DQ_W/8 | Per-byte write mask, 1 blocks the byte |
| core_we | output | 1 | Core write enable |
| core_addr | output | COL_W-1 | Core word address |
| core_data | output | 2*DQ_W | Core write word |
| core_be | output | 2*DQ_W/8 | Core byte enables |

## Verification
A ping-pong pointer that falls out of step with the strobe shows up at the ports as words repeated or swapped within a burst. The error appears on the second write of the burst. A wrong latency count moves the whole burst by a cycle, which the bench catches at the first write, three cycles after the command. A stale burst counter shows as a write too many or too few once the expected count has elapsed. A missed busy guard shows as extra writes carrying the poked start's column a few cycles after the poke. Random bursts cover all lengths and all mask patterns. Directed bursts cover the address wrap, the unused code and a start during a burst.

// File: rtl/ddr_wr_capture.sv
`timescale 1ns/1ps
module ddr_wr_capture #(
  parameter int DQ_W  = 16,
  parameter int COL_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_start,
  input  logic [COL_W-1:0]      wr_col,
  input  logic [1:0]            wr_blen,
  input  logic                  dqs,
  input  logic [DQ_W-1:0]       dq,
  input  logic [DQ_W/8-1:0]     dm,
  output logic                  core_we,
  output logic [COL_W-2:0]      core_addr,
  output logic [2*DQ_W-1:0]     core_data,
  output logic [2*DQ_W/8-1:0]   core_be
);
  localparam int NB = DQ_W / 8;
  localparam int AW = COL_W - 1;
  localparam int WW = 2 * DQ_W;

  // strobe domain: rising beat held, pair pushed on falling edge
  logic [DQ_W-1:0] rise_d;
  logic [NB-1:0]   rise_m;
  logic [WW-1:0]   slot_d [2];
  logic [2*NB-1:0] slot_m [2];
  logic            wptr;

  always_ff @(posedge dqs or negedge rst_n)
    if (!rst_n) begin
      rise_d <= '0;
      rise_m <= '0;
    end else begin
      rise_d <= dq;
      rise_m <= dm;
    end

  always_ff @(negedge dqs or negedge rst_n)
    if (!rst_n) begin
      wptr <= 1'b0;
      for (int i = 0; i < 2; i++) begin
        slot_d[i] <= '0;
        slot_m[i] <= '0;
      end
    end else begin
      slot_d[wptr] <= {dq, rise_d};
      slot_m[wptr] <= {dm, rise_m};
      wptr         <= ~wptr;
    end

  // core domain: fixed-latency drain
  logic          busy;
  logic [1:0]    dly;
  logic [2:0]    left;
  logic [AW-1:0] next_a;
  logic          rptr;
  logic [2:0]    words;

  assign words = (wr_blen == 2'd1) ? 3'd1 : (wr_blen == 2'd2) ? 3'd2 : 3'd4;

  wire accept = wr_start && !busy && (wr_blen != 2'd0);
  wire go     = busy && (dly == 2'd0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy      <= 1'b0;
      dly       <= 2'd0;
      left      <= 3'd0;
      next_a    <= '0;
      rptr      <= 1'b0;
      core_we   <= 1'b0;
      core_addr <= '0;
      core_data <= '0;
      core_be   <= '0;
    end else begin
      core_we <= go;
      if (accept) begin
        busy   <= 1'b1;
        dly    <= 2'd2;
        left   <= words;
        next_a <= wr_col[COL_W-1:1];
      end else if (busy) begin
        if (dly != 2'd0) dly <= dly - 2'd1;
        else begin
          core_addr <= next_a;
          core_data <= slot_d[rptr];
          core_be   <= ~slot_m[rptr];
          rptr      <= ~rptr;
          next_a    <= next_a + 1'b1;
          left      <= left - 3'd1;
          if (left == 3'd1) busy <= 1'b0;
        end
      end
    end

  logic [2:0] run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= 3'd0;
    else        run <= core_we ? run + 3'd1 : 3'd0;

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_we && $past(core_we) |-> core_addr == AW'($past(core_addr) + 1'b1));

  assert_first_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_we) |-> core_addr == $past(wr_col[COL_W-1:1], 4));

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_we) |-> $past(accept, 4));

  assert_burst_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    core_we |-> run < 3'd4);
endmodule

// File: tb/tb_ddr_wr_capture.sv
`timescale 1ns/1ps
module tb_ddr_wr_capture;
  localparam int DQ_W = 16, COL_W = 10, NB = 2, AW = 9;

  logic clk = 0, rst_n = 0, wr_start = 0, dqs = 0;
  logic [COL_W-1:0] wr_col = '0;
  logic [1:0] wr_blen = '0;
  logic [DQ_W-1:0] dq = '0;
  logic [NB-1:0] dm = '0;
  logic core_we;
  logic [AW-1:0] core_addr;
  logic [2*DQ_W-1:0] core_data;
  logic [2*NB-1:0] core_be;

  ddr_wr_capture #(.DQ_W(DQ_W), .COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_col(wr_col), .wr_blen(wr_blen),
    .dqs(dqs), .dq(dq), .dm(dm), .core_we(core_we), .core_addr(core_addr),
    .core_data(core_data), .core_be(core_be));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int lcyc [256];
  logic [AW-1:0] laddr [256];
  logic [2*DQ_W-1:0] ldata [256];
  logic [2*NB-1:0] lbe [256];
  int ntotal = 0;
  always @(negedge clk) if (core_we) begin
    lcyc[ntotal % 256]  <= cyc;
    laddr[ntotal % 256] <= core_addr;
    ldata[ntotal % 256] <= core_data;
    lbe[ntotal % 256]   <= core_be;
    ntotal <= ntotal + 1;
  end

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int nwords(input logic [1:0] bl);
    return (bl == 2'd1) ? 1 : (bl == 2'd2) ? 2 : (bl == 2'd3) ? 4 : 0;
  endfunction

  task automatic burst(input logic [COL_W-1:0] col, input logic [1:0] bl,
                       input int mmode, input bit poke);
    logic [DQ_W-1:0] r [4], f [4];
    logic [NB-1:0] rm [4], fm [4];
    logic [AW-1:0] ea;
    int w, base, t0, idx;
    w = nwords(bl);
    for (int i = 0; i < 4; i++) begin
      r[i] = DQ_W'($urandom); f[i] = DQ_W'($urandom);
      rm[i] = (mmode == 0) ? '0 : (mmode == 1) ? '1 : NB'($urandom);
      fm[i] = (mmode == 0) ? '0 : (mmode == 1) ? '1 : NB'($urandom);
    end
    @(negedge clk);
    wr_col = col; wr_blen = bl; wr_start = 1; base = ntotal;
    @(posedge clk); #1;
    t0 = cyc; wr_start = 0; wr_col = COL_W'($urandom);
    for (int i = 0; i < w; i++) begin
      @(posedge clk); #0.5;
      dq = r[i]; dm = rm[i];
      if (poke && i == 0) begin wr_start = 1; wr_col = ~col; wr_blen = 2'd3; end
      if (poke && i == 1) wr_start = 0;
      #0.75 dqs = 1;
      #1.25 dq = f[i]; dm = fm[i];
      #1.25 dqs = 0;
    end
    repeat (6) @(posedge clk);
    #1;
    check(ntotal - base == w, poke ? "R7" : "R5", "write count", ntotal - base, w);
    for (int k = 0; k < w; k++) begin
      idx = (base + k) % 256;
      ea = col[COL_W-1:1] + AW'(k);
      check(lcyc[idx] == t0 + 3 + k, "R6", "write cycle", lcyc[idx], t0 + 3 + k);
      check(laddr[idx] == ea, poke ? "R7" : "R4", "address", laddr[idx], ea);
      check(ldata[idx] == {f[k], r[k]}, "R2", "data", ldata[idx], {f[k], r[k]});
      check(lbe[idx] == ~{fm[k], rm[k]}, "R3", "byte enables", lbe[idx], ~{fm[k], rm[k]});
    end
    check(core_we == 1'b0, "R8", "we after burst", core_we, 0);
  endtask

  task automatic run_all();
    repeat (3) @(posedge clk);
    #1;
    check(core_we == 1'b0, "R1", "we in reset", core_we, 0);
    rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    check(core_we == 1'b0, "R1", "we after reset", core_we, 0);
    burst(10'h010, 2'd1, 0, 0);
    burst(10'h021, 2'd2, 1, 0);
    burst(10'h100, 2'd3, 2, 0);
    burst(10'h3FC, 2'd3, 0, 0);
    burst(10'h050, 2'd0, 0, 0);
    burst(10'h0A4, 2'd3, 2, 1);
    for (int n = 0; n < 24; n++)
      burst(COL_W'($urandom), 2'(1 + $urandom % 3), 2, 0);
  endtask

  initial begin
    bit wd;
    wd = 0;
    void'($urandom(32'd4177));
    fork
      run_all();
      begin wait (cyc > 20000); wd = 1; end
    join_any
    disable fork;
    if (wd) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 20000);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule